// File: doc/BRIEF.md
# Per-Pin Interrupt Trigger Evaluator

This block decides, for a bank of input pins, which pins currently have a qualifying interrupt. Each pin carries four trigger-type bits that are set independently of one another: rising edge, falling edge, high level and low level. The block keeps a copy of the level each pin had when it was last sampled. Edge triggers are derived by comparing that copy with the new level. Level triggers are ORed in on top. The combined vector is then masked by an external status byte and an external enable byte.

A controller presents the current pin levels, the status and enable bytes and the four type masks, then pulses the evaluate strobe. One clock later the block shows the masked pending vector together with a single-cycle valid pulse. At start-up the controller pulses the snapshot-load input. This seeds the stored levels from the live pins, so the first evaluation does not report edges that never happened. Handing the pending pins on to handlers is left to the logic downstream.

Top module: `pin_trigger_eval`

## Requirements
- R1: After reset, the stored level copy is all zeros, `pend` is zero and `pend_valid` is low. An asynchronous reset clears both outputs at once.
- R2: `pend_valid` goes high for exactly one clock, in the cycle after each clock in which `eval_strobe` was high, and is low at every other time.
- R3: A pin whose rise bit is set becomes pending when its stored level is 0 and its evaluated level is 1. An unchanged level gives no edge.
- R4: A pin whose fall bit is set becomes pending when its stored level is 1 and its evaluated level is 0.
- R5: A pin whose high bit is set is pending whenever its evaluated level is 1, whether or not the level changed.
- R6: A pin whose low bit is set is pending whenever its evaluated level is 0, whether or not the level changed.
- R7: The pending vector is the trigger result ANDed with `irq_status` and `irq_enable`, bit by bit.
- R8: A pin with all four type bits clear never appears in `pend`, whatever its status, enable and level are.
- R9: Every evaluate strobe replaces the stored level copy with the level that was just evaluated.
- R10: A `snap_load` pulse stores the current levels and gives no valid pulse. When `snap_load` and `eval_strobe` are high in the same clock, the evaluation uses the copy stored before that clock.
- R11: `pend` keeps its value in every clock without an evaluate strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | PINS | Current pin levels |
| irq_status | input | PINS | Per-pin status bits from the pin hardware |
| irq_enable | input | PINS | Per-pin interrupt enables |
| trig_rise | input | PINS | Rising-edge trigger selection |
| trig_fall | input | PINS | Falling-edge trigger selection |
| trig_high | input | PINS | High-level trigger selection |
| trig_low | input | PINS | Low-level trigger selection |
| eval_strobe | input | 1 | Evaluate the current inputs |
| snap_load | input | 1 | Store the current levels without evaluating |
| pend | output | PINS | Masked pending vector |
| pend_valid | output | 1 | One-cycle pulse marking a new `pend` |

## Verification
The two actions that can coincide are a snapshot load and an evaluation. Both write the stored level copy in the same clock, and only the evaluation reads it. The bench first seeds the copy with one byte. In a later clock it raises both strobes together while presenting the complement of that byte. All pins have rise selected, so the expected pending value is exactly the set bits of the new byte. That result can only appear if the old copy was used for the comparison. A further evaluation at the same level must then return zero, which shows that the copy now holds the new byte.

// File: rtl/pte_pkg.sv
package pte_pkg;
  // Trigger selection held for one pin; the four bits are independent.
  typedef struct packed {
    logic rise;
    logic fall;
    logic high;
    logic low;
  } trig_sel_t;
endpackage

// File: rtl/pte_rst_sync.sv
module pte_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pte_level_snapshot.sv
module pte_level_snapshot #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [PINS-1:0] level,
  output logic [PINS-1:0] prev_q
);
  logic [PINS-1:0] prev_d;

  always_comb begin
    prev_d = prev_q;
    if (capture) prev_d = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  AST_SNAP_TRACKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (prev_q == $past(level)));  // R9
  AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(prev_q));  // R10
endmodule

// File: rtl/pte_trigger_logic.sv
module pte_trigger_logic
  import pte_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic [PINS-1:0]            level,
  input  logic [PINS-1:0]            prev,
  input  trig_sel_t [PINS-1:0]       sel,
  input  logic [PINS-1:0]            status,
  input  logic [PINS-1:0]            enable,
  output logic [PINS-1:0]            pend_raw
);
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic moved;
    logic edge_hit;
    logic lvl_hit;
    always_comb begin
      moved    = level[p] ^ prev[p];
      edge_hit = moved & ((sel[p].rise & level[p]) | (sel[p].fall & ~level[p]));
      lvl_hit  = (sel[p].high & level[p]) | (sel[p].low & ~level[p]);
      pend_raw[p] = (edge_hit | lvl_hit) & status[p] & enable[p];
    end
  end
endmodule

// File: rtl/pte_pend_reg.sv
module pte_pend_reg #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eval,
  input  logic [PINS-1:0] pend_raw,
  output logic [PINS-1:0] pend_q,
  output logic            vld_q
);
  logic [PINS-1:0] pend_d;
  logic            vld_d;

  always_comb begin
    pend_d = pend_q;
    if (eval) pend_d = pend_raw;
    vld_d = eval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      vld_q  <= vld_d;
    end
  end

  AST_VALID_AFTER_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    eval |=> vld_q);  // R2
  AST_VALID_NEEDS_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> !vld_q);  // R2
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> $stable(pend_q));  // R11
endmodule

// File: rtl/pin_trigger_eval.sv
module pin_trigger_eval
  import pte_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_level,
  input  logic [PINS-1:0] irq_status,
  input  logic [PINS-1:0] irq_enable,
  input  logic [PINS-1:0] trig_rise,
  input  logic [PINS-1:0] trig_fall,
  input  logic [PINS-1:0] trig_high,
  input  logic [PINS-1:0] trig_low,
  input  logic            eval_strobe,
  input  logic            snap_load,
  output logic [PINS-1:0] pend,
  output logic            pend_valid
);
  logic                  rst_i_n;
  logic                  snap_capture;
  logic [PINS-1:0]       prev_lvl;
  logic [PINS-1:0]       pend_raw;
  trig_sel_t [PINS-1:0]  sel;

  for (genvar p = 0; p < PINS; p++) begin : g_sel
    always_comb begin
      sel[p].rise = trig_rise[p];
      sel[p].fall = trig_fall[p];
      sel[p].high = trig_high[p];
      sel[p].low  = trig_low[p];
    end
  end

  assign snap_capture = eval_strobe | snap_load;

  pte_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_i_n)
  );

  pte_level_snapshot #(.PINS(PINS)) i_snapshot (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .capture (snap_capture),
    .level   (pin_level),
    .prev_q  (prev_lvl)
  );

  pte_trigger_logic #(.PINS(PINS)) i_trigger (
    .level    (pin_level),
    .prev     (prev_lvl),
    .sel      (sel),
    .status   (irq_status),
    .enable   (irq_enable),
    .pend_raw (pend_raw)
  );

  pte_pend_reg #(.PINS(PINS)) i_pend_reg (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .eval     (eval_strobe),
    .pend_raw (pend_raw),
    .pend_q   (pend),
    .vld_q    (pend_valid)
  );

  AST_NO_TYPE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_i_n)
    eval_strobe |=> ((pend & ~$past(trig_rise | trig_fall | trig_high | trig_low)) == '0));  // R8
  AST_MASKED_BY_GATES: assert property (@(posedge clk) disable iff (!rst_i_n)
    eval_strobe |=> ((pend & ~$past(irq_status & irq_enable)) == '0));  // R7
  AST_EDGE_NEEDS_MOVE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (eval_strobe && (trig_high == '0) && (trig_low == '0)) |=>
      ((pend & ~($past(pin_level) ^ $past(prev_lvl))) == '0));  // R3
endmodule

// File: tb/test_pin_trigger_eval.sv
module test_pin_trigger_eval;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pin_level, irq_status, irq_enable;
  logic [7:0] trig_rise, trig_fall, trig_high, trig_low;
  logic       eval_strobe, snap_load;
  logic [7:0] pend;
  logic       pend_valid;

  int checks = 0;
  int failures = 0;

  // Fields: level, status, enable, rise, fall, high, low, expected pending
  localparam logic [63:0] VEC [NVEC] = '{
    64'h0FFFFFFF0000000F,  // R3 rise from reset copy 00
    64'hF0FFFF00FF00000F,  // R4 fall
    64'hF0FFFFFFFF000000,  // R3 no change, no edge
    64'hA5FFFF0000FF00A5,  // R5 high level
    64'hA5FFFF000000FF5A,  // R6 low level, unchanged
    64'h5AF03CFFFF000030,  // R7 both edges masked by status and enable
    64'hFFFFFF0F0000F005,  // R3 partial rise
    64'h00FFFF0000000000,  // R8 no type bits
    64'h8181010100800001,  // R7 mixed edge and level, enable masks
    64'h81FFFF000000FE7E   // R6 low level
  };
  localparam int VREQ [NVEC] = '{3, 4, 3, 5, 6, 7, 3, 8, 7, 6};

  pin_trigger_eval i_pin_trigger_eval (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_level   (pin_level),
    .irq_status  (irq_status),
    .irq_enable  (irq_enable),
    .trig_rise   (trig_rise),
    .trig_fall   (trig_fall),
    .trig_high   (trig_high),
    .trig_low    (trig_low),
    .eval_strobe (eval_strobe),
    .snap_load   (snap_load),
    .pend        (pend),
    .pend_valid  (pend_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] lv, st, en, ri, fa, hi, lo,
                       input logic ev, input logic ld);
    pin_level = lv; irq_status = st; irq_enable = en;
    trig_rise = ri; trig_fall = fa; trig_high = hi; trig_low = lo;
    eval_strobe = ev; snap_load = ld;
    @(negedge clk);
    eval_strobe = 1'b0; snap_load = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pin_level = '0; irq_status = '0; irq_enable = '0;
    trig_rise = '0; trig_fall = '0; trig_high = '0; trig_low = '0;
    eval_strobe = 1'b0; snap_load = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pend in reset", pend, 8'h00);
    chk("R1 valid in reset", {7'b0, pend_valid}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [63:0] v;
      v = VEC[i];
      drive(v[63:56], v[55:48], v[47:40], v[39:32], v[31:24], v[23:16], v[15:8], 1'b1, 1'b0);
      chk($sformatf("R%0d vector %0d pend", VREQ[i], i), pend, v[7:0]);
      chk($sformatf("R2 vector %0d valid high", i), {7'b0, pend_valid}, 8'h01);
      @(negedge clk);
      chk($sformatf("R2 vector %0d valid dropped", i), {7'b0, pend_valid}, 8'h00);
      chk($sformatf("R11 vector %0d pend held", i), pend, v[7:0]);
    end

    // R10: load alone stores the level and raises no valid
    drive(8'h3C, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
    chk("R10 load gives no valid", {7'b0, pend_valid}, 8'h00);
    chk("R10 load leaves pend", pend, 8'h7E);
    drive(8'h3C, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0);
    chk("R10 no edge after load", pend, 8'h00);
    // R10: load and evaluate together compare against the older copy
    drive(8'hC3, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1);
    chk("R10 joint load and eval", pend, 8'hC3);
    chk("R10 joint valid", {7'b0, pend_valid}, 8'h01);
    drive(8'hC3, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0);
    chk("R9 copy updated after joint", pend, 8'h00);
    // R8: level changes on pins with no type bits
    drive(8'h3C, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    chk("R8 untyped pins stay quiet", pend, 8'h00);

    // R1: asynchronous reset in the middle of a run
    drive(8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0);
    chk("R5 all high before reset", pend, 8'hFF);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear pend", pend, 8'h00);
    chk("R1 async clear valid", {7'b0, pend_valid}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(8'h01, 8'hFF, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    chk("R1 copy zero after reset", pend, 8'h01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule